// File: doc/BRIEF.md
# Linked-Line Character Display Fetcher

This block feeds a character generator stage. Text for one screen sits in two byte-wide banks that share one 12-bit offset. The character bank holds codes and the attribute bank holds per-character attributes. Lines do not sit at fixed places in memory. Each line ends with a terminator code, and the two bytes after it give the offset of the next line to show. The attribute byte paired with the first pointer byte carries the size and scroll flags of the line that the pointer selects.

A frame-start pulse restarts the walk at offset 0 and samples the smooth-scroll value for the whole frame. The block passes over each line once for every scan row it shows. For each visible character it emits one output word: the character code, the decoded character attributes, the current line's attributes and the scan row number.

A line shows rows 0 to 9, except at the edges of a scrolling region when the scroll value N is not zero. There, the first line of the region starts at row N and the last line of the region stops at row N-1. The read port has one cycle of latency. An output word appears two cycles after the read that fetched it.

Top module: `linked_line_fetch`

## Requirements
- R1: In the cycle after `frame_start` is sampled high, `mem_rd` is 1 and `mem_addr` is 0. Any read in flight when the pulse arrives is discarded, even in the middle of a frame.
- R2: Character and attribute bytes come from the same offset `mem_addr`, one cycle after `mem_rd`. Within one scan row, characters are emitted in increasing offset order.
- R3: Code 0xFF is the end-of-line marker and is never emitted. The next two bytes are the next line's offset, low byte first. Fetching continues there using the low ADDR_W bits.
- R4: A line is passed over once for each scan row it shows, in rising row order. Every visible character is emitted once per pass, and `out_row` gives the row.
- R5: `out_cattr` is the inverse of attribute bits 3:0, which are active low: bit 0 reverse, bit 1 bold, bit 2 blink, bit 3 underline. Attribute bits 7:4 have no effect.
- R6: Line attributes come from the attribute byte paired with the pointer's low byte. Bit 0 drives `out_scroll`. Bits 2:1 drive `out_size`: 00 bottom half of double height, 01 top half of double height, 10 double width, 11 normal. Bits 7:3 have no effect. The line at offset 0 always has scroll 0 and size 11.
- R7: Let N be the latched scroll value. A region's first line (scroll set, previous line clear) shows rows N..9. A region's last line (scroll set, next line clear) shows rows 0..N-1. With N=0, every line shows rows 0..9.
- R8: `scroll_in` is sampled only with `frame_start`, so changes during a frame do not take effect until the next frame. A value of 10 or more is taken as 0.
- R9: A one-line region, whose line is both first and last, shows rows N..9.
- R10: After reset, and until the first `frame_start`, `mem_rd` and `out_valid` stay 0.
- R11: Every `out_valid` cycle follows a `mem_rd` cycle by exactly two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Vertical reset pulse: restart at offset 0 and latch the scroll value |
| scroll_in | input | 4 | Smooth-scroll value for the next frame |
| mem_rd | output | 1 | Read strobe to both banks |
| mem_addr | output | ADDR_W (12) | Offset shared by both banks |
| char_data | input | 8 | Character bank byte, one cycle after the read |
| attr_data | input | 8 | Attribute bank byte, one cycle after the read |
| out_valid | output | 1 | Output word valid |
| out_code | output | 8 | Character code |
| out_cattr | output | 4 | Active-high reverse, bold, blink, underline (bits 0..3) |
| out_scroll | output | 1 | Current line lies in a scroll region |
| out_size | output | 2 | Current line size code |
| out_row | output | 4 | Scan row of this pass |

## Verification
Many faults in the walk show up as the wrong number of output words. A wrong read-kind tag or pointer register makes the walk skip lines, repeat lines or leak a terminator. The bench sees this within the first scan row of the affected line. A wrong row counter or a wrong region-edge flag instead shifts the `out_row` values of the first or last line of a region. Those rows only differ from the expected ones when N is not zero, so the bench runs several values of N, a one-line region and a scroll change made in the middle of a frame. A stale in-flight read after `frame_start` would show up as an extra word at the very start of the next frame.

// File: rtl/lfetch_pkg.sv
package lfetch_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PHI, ST_WAIT} fstate_e;
    typedef enum logic [1:0] {RD_NONE, RD_CHAR, RD_PLO, RD_PHI} rdkind_e;
    localparam int          BYTE_W      = 8;
    localparam int          CATTR_W     = 4;
    localparam int          LATTR_W     = 3;
    localparam logic [7:0]  TERM_CODE   = 8'hFF;
    localparam logic [1:0]  SIZE_NORMAL = 2'b11;
endpackage

// File: rtl/fetch_attr_unpack.sv
module fetch_attr_unpack
    import lfetch_pkg::*;
(
    input  logic [BYTE_W-1:0]  code,
    input  logic [CATTR_W-1:0] attr_lo,
    output logic               is_term,
    output logic [CATTR_W-1:0] cattr
);
    // Stored attribute bits are active low; present them active high.
    always_comb begin
        is_term = (code == TERM_CODE);
        cattr   = ~attr_lo;
    end
endmodule

// File: rtl/fetch_row_window.sv
module fetch_row_window #(
    parameter int ROWS = 10
) (
    input  logic [$clog2(ROWS)-1:0] nlat,
    input  logic                    prev_s,
    input  logic                    cur_s,
    input  logic                    next_s,
    output logic [$clog2(ROWS)-1:0] cur_end,
    output logic [$clog2(ROWS)-1:0] next_start
);
    localparam int RW = $clog2(ROWS);

    logic cur_first, cur_last, next_first, n_zero;

    always_comb begin
        n_zero     = (nlat == '0);
        cur_first  = cur_s & ~prev_s;
        cur_last   = cur_s & ~next_s;
        next_first = next_s & ~cur_s;
        // A region's last line is cut short, unless it is also the first line.
        if (cur_last && !cur_first && !n_zero)
            cur_end = nlat - RW'(1);
        else
            cur_end = RW'(ROWS - 1);
        // A region's first line begins part way down.
        if (next_first && !n_zero)
            next_start = nlat;
        else
            next_start = '0;
    end
endmodule

// File: rtl/linked_line_fetch.sv
module linked_line_fetch
    import lfetch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ROWS   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic [$clog2(ROWS)-1:0] scroll_in,
    output logic                    mem_rd,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [7:0]              char_data,
    input  logic [7:0]              attr_data,
    output logic                    out_valid,
    output logic [7:0]              out_code,
    output logic [3:0]              out_cattr,
    output logic                    out_scroll,
    output logic [1:0]              out_size,
    output logic [$clog2(ROWS)-1:0] out_row
);
    localparam int RW    = $clog2(ROWS);
    localparam int PTR_W = 2 * BYTE_W;

    typedef struct packed {
        fstate_e             st;
        rdkind_e             kind;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   base;
        logic [RW-1:0]       row;
        logic [RW-1:0]       nlat;
        logic                cur_scroll;
        logic                prev_scroll;
        logic [1:0]          cur_size;
        logic [BYTE_W-1:0]   plo;
        logic [LATTR_W-1:0]  plo_lat;
        logic                ovalid;
        logic [BYTE_W-1:0]   ocode;
        logic [CATTR_W-1:0]  ocattr;
        logic                oscroll;
        logic [1:0]          osize;
        logic [RW-1:0]       orow;
    } fetch_state_t;

    fetch_state_t q, d;

    logic               is_term;
    logic [CATTR_W-1:0] cattr;
    logic [RW-1:0]      cur_end, next_start;
    logic [RW-1:0]      nlat_in;
    logic [PTR_W-1:0]   ptr_full;
    logic               rd_c;

    fetch_attr_unpack u_unpack (
        .code    (char_data),
        .attr_lo (attr_data[CATTR_W-1:0]),
        .is_term (is_term),
        .cattr   (cattr)
    );

    fetch_row_window #(.ROWS(ROWS)) u_rows (
        .nlat       (q.nlat),
        .prev_s     (q.prev_scroll),
        .cur_s      (q.cur_scroll),
        .next_s     (q.plo_lat[0]),
        .cur_end    (cur_end),
        .next_start (next_start)
    );

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        d.kind   = RD_NONE;
        rd_c     = 1'b0;
        ptr_full = {char_data, q.plo};
        nlat_in  = (int'(scroll_in) < ROWS) ? scroll_in : '0;

        case (q.st)
            ST_RUN: begin
                rd_c   = 1'b1;
                d.addr = q.addr + ADDR_W'(1);
                d.kind = RD_CHAR;
                if (q.kind == RD_CHAR) begin
                    if (is_term) begin
                        // The read going out now is the pointer low byte.
                        d.kind = RD_PLO;
                        d.st   = ST_PHI;
                    end else begin
                        d.ovalid  = 1'b1;
                        d.ocode   = char_data;
                        d.ocattr  = cattr;
                        d.oscroll = q.cur_scroll;
                        d.osize   = q.cur_size;
                        d.orow    = q.row;
                    end
                end
            end
            ST_PHI: begin
                rd_c   = 1'b1;
                d.kind = RD_PHI;
                if (q.kind == RD_PLO) begin
                    d.plo     = char_data;
                    d.plo_lat = attr_data[LATTR_W-1:0];
                end
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (q.kind == RD_PHI) begin
                    if (q.row != cur_end) begin
                        d.row  = q.row + RW'(1);
                        d.addr = q.base;
                    end else begin
                        d.base        = ptr_full[ADDR_W-1:0];
                        d.addr        = ptr_full[ADDR_W-1:0];
                        d.prev_scroll = q.cur_scroll;
                        d.cur_scroll  = q.plo_lat[0];
                        d.cur_size    = q.plo_lat[2:1];
                        d.row         = next_start;
                    end
                    d.st = ST_RUN;
                end
            end
            default: ;
        endcase

        if (frame_start) begin
            d.st          = ST_RUN;
            d.kind        = RD_NONE;
            d.addr        = '0;
            d.base        = '0;
            d.row         = '0;
            d.nlat        = nlat_in;
            d.cur_scroll  = 1'b0;
            d.prev_scroll = 1'b0;
            d.cur_size    = SIZE_NORMAL;
            d.ovalid      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd     = rd_c;
    assign mem_addr   = q.addr;
    assign out_valid  = q.ovalid;
    assign out_code   = q.ocode;
    assign out_cattr  = q.ocattr;
    assign out_scroll = q.oscroll;
    assign out_size   = q.osize;
    assign out_row    = q.orow;
endmodule

// File: rtl/linked_line_fetch_chk.sv
module linked_line_fetch_chk #(
    parameter int ADDR_W = 12,
    parameter int ROWS   = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_start,
    input logic                    mem_rd,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic                    out_valid,
    input logic [7:0]              out_code,
    input logic [$clog2(ROWS)-1:0] out_row
);
    // R1
    restart_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_rd && mem_addr == '0));

    // R3
    no_terminator_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code != 8'hFF));

    // R4
    row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_row) < ROWS));

    // R11
    read_to_out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_rd, 2));
endmodule

bind linked_line_fetch linked_line_fetch_chk #(.ADDR_W(ADDR_W), .ROWS(ROWS)) u_chk (.*);

// File: tb/tb_linked_line_fetch.sv
module tb_linked_line_fetch;
    localparam int ADDR_W = 12;
    localparam int ROWS   = 10;
    localparam int RW     = 4;
    localparam int NFR    = 6;
    // per frame: {scroll value at frame start, value applied mid-frame}
    localparam int FRAMES [NFR][2] = '{'{0,3}, '{5,9}, '{1,0}, '{9,2}, '{12,4}, '{3,3}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, frame_start;
    logic [RW-1:0]     scroll_in;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        char_data = '0, attr_data = '0;
    logic              out_valid, out_scroll;
    logic [7:0]        out_code;
    logic [3:0]        out_cattr;
    logic [1:0]        out_size;
    logic [RW-1:0]     out_row;

    linked_line_fetch #(.ADDR_W(ADDR_W), .ROWS(ROWS)) dut (.*);

    logic [7:0] cmem [256];
    logic [7:0] amem [256];
    always @(posedge clk) if (mem_rd) begin
        char_data <= cmem[mem_addr[7:0]];
        attr_data <= amem[mem_addr[7:0]];
    end

    int checks = 0, fails = 0, lat_bad = 0;
    bit done = 0;
    logic rd1 = 0, rd2 = 0, cap_en = 0;
    logic [18:0] got [$];
    logic [18:0] exp_q [$];
    int lbase [5] = '{'h00, 'h20, 'h40, 'h60, 'h80};
    int lcnt  [5] = '{2, 1, 2, 1, 0};
    logic [7:0] link [5];

    task automatic check(input bit ok, input string tag, input longint act, input longint ex);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, ex);
        end
    endtask

    always @(negedge clk) begin
        if (out_valid && !rd2) lat_bad++;
        rd2 = rd1;
        rd1 = mem_rd;
        if (cap_en && out_valid)
            got.push_back({out_code, out_cattr, out_scroll, out_size, out_row});
    end

    task automatic load_screen(input logic [7:0] l12);
        link = '{8'hF7, l12, 8'hD8, 8'h04, 8'h04};
        for (int i = 0; i < 256; i++) begin cmem[i] = 8'h20; amem[i] = 8'h0F; end
        for (int i = 0; i < 5; i++) begin
            int b = lbase[i];
            int nb = (i < 4) ? lbase[i+1] : lbase[4];
            for (int k = 0; k < lcnt[i]; k++) begin
                cmem[b+k] = 8'(8'h41 + i*4 + k);
                amem[b+k] = {4'(i + k + 5), 4'(i*3 + k*5)};
            end
            cmem[b+lcnt[i]]   = 8'hFF; amem[b+lcnt[i]]   = 8'h5A;
            cmem[b+lcnt[i]+1] = 8'(nb); amem[b+lcnt[i]+1] = link[i];
            cmem[b+lcnt[i]+2] = 8'h00;  amem[b+lcnt[i]+2] = 8'hC3;
        end
    endtask

    // Expected stream from R4..R9 for the loaded screen
    task automatic build_exp(input int n);
        int neff = (n < ROWS) ? n : 0;
        logic [2:0] lat [5];
        lat[0] = 3'b110;
        for (int i = 1; i < 5; i++) lat[i] = link[i-1][2:0];
        exp_q.delete();
        for (int i = 0; i < 4; i++) begin
            bit ps = (i == 0) ? 1'b0 : lat[i-1][0];
            bit cs = lat[i][0];
            bit ns = lat[i+1][0];
            bit first = cs && !ps;
            bit last  = cs && !ns;
            int rs = (first && neff != 0) ? neff : 0;
            int re = (last && !first && neff != 0) ? neff - 1 : ROWS - 1;
            for (int r = rs; r <= re; r++)
                for (int k = 0; k < lcnt[i]; k++)
                    exp_q.push_back({cmem[lbase[i]+k], ~amem[lbase[i]+k][3:0],
                                     lat[i][0], lat[i][2:1], 4'(r)});
        end
    endtask

    task automatic run_frame(input int n, input int later, input int cyc);
        @(negedge clk);
        frame_start = 1'b1; scroll_in = 4'(n);
        @(negedge clk);
        frame_start = 1'b0;
        check(mem_rd && mem_addr == '0, "R1 restart read", {mem_rd, mem_addr}, {1'b1, 12'h000});
        got.delete();
        cap_en = 1'b1;
        repeat (20) @(negedge clk);
        scroll_in = 4'(later);
        repeat (cyc) @(negedge clk);
        cap_en = 1'b0;
    endtask

    task automatic compare(input string rtag);
        int nff = 0;
        check(got.size() == exp_q.size(), "R4 word count", got.size(), exp_q.size());
        foreach (got[i]) if (got[i][18:11] == 8'hFF) nff++;
        check(nff == 0, "R3 terminator emitted", nff, 0);
        for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
            check(got[i][18:11] == exp_q[i][18:11], "R2 code order", got[i][18:11], exp_q[i][18:11]);
            check(got[i][10:7] == exp_q[i][10:7], "R5 char attr", got[i][10:7], exp_q[i][10:7]);
            check(got[i][6:4] == exp_q[i][6:4], "R6 line attr", got[i][6:4], exp_q[i][6:4]);
            check(got[i][3:0] == exp_q[i][3:0], rtag, got[i][3:0], exp_q[i][3:0]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; scroll_in = '0;
        load_screen(8'hE3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle until the first frame start
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(!mem_rd && !out_valid, "R10 idle after reset", {mem_rd, out_valid}, 0);
        end
        // R7 / R8: several scroll values, mid-frame change ignored, 12 acts as 0
        for (int f = 0; f < NFR; f++) begin
            run_frame(FRAMES[f][0], FRAMES[f][1], 450);
            build_exp(FRAMES[f][0]);
            compare((FRAMES[f][0] != FRAMES[f][1]) ? "R8 row window" : "R7 row window");
        end
        // R1: restart in the middle of a frame
        run_frame(4, 4, 90);
        run_frame(6, 6, 450);
        build_exp(6);
        compare("R1 row after restart");
        // R9: one-line scroll region
        load_screen(8'hE2);
        run_frame(7, 7, 450);
        build_exp(7);
        compare("R9 single line region");
        check(lat_bad == 0, "R11 read to output latency", lat_bad, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule